// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial control-port slave. It lets an external host read and write a small file of byte-wide registers over three wires: a serial clock, an active-low select and one data line. On the chip side that data line is split into an input, an output and an output enable. Every frame opens with a 16-bit command word. The command holds the transfer direction, a two-bit length code and a 13-bit start address. Data bytes follow the command. The length code selects one, two or three bytes, or an open-ended stream that ends only when select is released.

The port runs entirely on the system clock. It oversamples the serial pins through synchronisers and acts on the detected clock edges. Incoming bits are taken on rising serial-clock edges. Readback bits are launched on falling edges. A host may release select between bytes of a short transfer and pick up later where it stopped. Releasing select inside a byte throws the frame away. Bit 0 of register 0 selects the bit order, and each frame uses the value that bit held when the frame began.

Top module: `spiRegPort`

## Requirements
- R1: A frame starts on the first rising serial-clock edge after select goes low. Data-line bits are sampled on rising edges. The 16-bit command word is bit 15 = read (1) or write (0), bits 14:13 = length code, bits 12:0 = start address.
- R2: Length codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes. After the last byte, the next bits are decoded as a new command, even if select never went high.
- R3: Length code 11 streams data bytes until select goes high. That release at a byte boundary ends the frame.
- R4: In a 1-, 2- or 3-byte transfer, releasing select at a byte boundary pauses the frame. The frame continues with the next byte when select returns low.
- R5: Releasing select partway through any byte, in the command or in the data, aborts the frame. The partial byte is dropped, no register changes, and the next bits are read as a fresh command.
- R6: In a read frame the output enable is low during the command. It rises on the first falling edge after the 16th command bit, and a new output bit is driven on each falling edge. The enable is low whenever select is high and after the frame ends.
- R7: Between successive data bytes the address steps down by one in MSB-first order and up by one in LSB-first order. It wraps modulo 2^13.
- R8: After reset the bit order is MSB-first. Writing 1 to bit 0 of register 0 makes later frames LSB-first, for both the command word and the data.
- R9: A written byte is stored only once its eighth bit has been sampled. Writes to addresses at or beyond the register count are ignored, and reads from those addresses return 0x00.
- R10: After reset every register holds 0x00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| spiClk | input | 1 | Serial clock from the host, idle low |
| spiCsN | input | 1 | Frame select from the host, active low |
| spiDataIn | input | 1 | Data line as seen at the pad input |
| spiDataOut | output | 1 | Readback data toward the pad |
| spiDataOe | output | 1 | Pad output enable, high while the port drives the data line |

## Verification
The bench builds the port with eight registers and two synchroniser stages, and runs the serial clock at one sixteenth of the system clock. Eight registers put register 0 (the order bit) and both ends of the map within reach of ordinary multi-byte transfers. Streams that run past address 7, and a direct write to address 20, exercise the unimplemented space. Two synchroniser stages keep the detection delay well inside a serial half period, so the turnaround timing and the released enable during a pause can be observed at the pins.

// File: rtl/spiPortPkg.sv
`timescale 1ns/1ps
package spiPortPkg;
  localparam int CMD_BITS  = 16;
  localparam int ADDR_W    = 13;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // Strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic                 shiftBit;
    logic                 latchAddr;
    logic                 stepAddr;
    logic                 writeByte;
    logic                 loadRead;
    logic                 driveBit;
    logic                 lsbOrder;
    logic [BIT_IDX_W-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/spiPinSync.sv
`timescale 1ns/1ps
module spiPinSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkPin,
  input  logic csNPin,
  input  logic dataPin,
  output logic sclkRise,
  output logic sclkFall,
  output logic csActive,
  output logic dataBit
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sclkSh, csSh, dataSh;
  logic sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSh   <= '0;
      csSh     <= '1;
      dataSh   <= '0;
      sclkLast <= 1'b0;
    end else begin
      sclkSh   <= {sclkSh[STAGES-2:0], sclkPin};
      csSh     <= {csSh[STAGES-2:0], csNPin};
      dataSh   <= {dataSh[STAGES-2:0], dataPin};
      sclkLast <= sclkSh[TOP];
    end
  end

  // Data runs through the same depth as the clock, so they stay aligned
  assign sclkRise = sclkSh[TOP] & ~sclkLast;
  assign sclkFall = ~sclkSh[TOP] & sclkLast;
  assign csActive = ~csSh[TOP];
  assign dataBit  = dataSh[TOP];
endmodule

// File: rtl/spiPortCtrl.sv
`timescale 1ns/1ps
module spiPortCtrl
  import spiPortPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkRise,
  input  logic    sclkFall,
  input  logic    csActive,
  input  logic [2:0] cmdHi,     // {read, len[1:0]} of the word being completed
  input  logic    cfgLsb,
  output strobe_t strobe,
  output logic    rdOn
);
  localparam logic [3:0] CMD_LAST  = 4'(CMD_BITS - 1);
  localparam logic [3:0] BYTE_LAST = 4'(BYTE_W - 1);

  phase_e     phase;
  logic [3:0] bitCnt;
  logic       isRead;
  logic [1:0] lenCode;
  logic [1:0] bytesLeft;
  logic       pendLoad;
  logic       frameLsb;

  logic idle, midByte, streaming, cmdDone, byteDone;

  assign idle      = (phase == PH_CMD) && (bitCnt == '0);
  assign midByte   = bitCnt[BIT_IDX_W-1:0] != '0;
  assign streaming = lenCode == 2'b11;
  assign cmdDone   = (phase == PH_CMD) && (bitCnt == CMD_LAST);
  assign byteDone  = (phase == PH_DATA) && (bitCnt == BYTE_LAST);

  always_comb begin
    strobe          = '0;
    strobe.lsbOrder = frameLsb;
    strobe.bitIdx   = bitCnt[BIT_IDX_W-1:0];
    strobe.loadRead = pendLoad;
    if (csActive && sclkRise) begin
      strobe.shiftBit  = 1'b1;
      strobe.latchAddr = cmdDone;
      strobe.stepAddr  = byteDone;
      strobe.writeByte = byteDone && !isRead;
    end
    if (csActive && sclkFall && phase == PH_DATA && isRead)
      strobe.driveBit = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      lenCode   <= '0;
      bytesLeft <= '0;
      pendLoad  <= 1'b0;
      frameLsb  <= 1'b0;
      rdOn      <= 1'b0;
    end else begin
      pendLoad <= 1'b0;
      if (idle) frameLsb <= cfgLsb;
      if (!csActive) begin
        // Inside a byte, or at the end of a stream: frame is over
        if (midByte || (phase == PH_DATA && streaming)) begin
          phase  <= PH_CMD;
          bitCnt <= '0;
          rdOn   <= 1'b0;
        end
      end else if (sclkRise) begin
        if (phase == PH_CMD) begin
          if (cmdDone) begin
            phase     <= PH_DATA;
            bitCnt    <= '0;
            isRead    <= cmdHi[2];
            lenCode   <= cmdHi[1:0];
            bytesLeft <= cmdHi[1:0];
            pendLoad  <= cmdHi[2];
          end else begin
            bitCnt <= bitCnt + 4'd1;
          end
        end else if (byteDone) begin
          bitCnt <= '0;
          if (!streaming && bytesLeft == '0) begin
            phase <= PH_CMD;
            rdOn  <= 1'b0;
          end else begin
            if (!streaming) bytesLeft <= bytesLeft - 2'd1;
            pendLoad <= isRead;
          end
        end else begin
          bitCnt <= bitCnt + 4'd1;
        end
      end else if (sclkFall && phase == PH_DATA && isRead) begin
        rdOn <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiPortData.sv
`timescale 1ns/1ps
module spiPortData
  import spiPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              dataBit,
  input  logic [BYTE_W-1:0] rdData,
  output logic [2:0]        cmdHi,
  output logic [ADDR_W-1:0] regAddr,
  output logic              wrEn,
  output logic [BYTE_W-1:0] wrData,
  output logic              outBit
);
  logic [CMD_BITS-1:0] shiftReg, shiftNext;
  logic [ADDR_W-1:0]   addr;
  logic [BYTE_W-1:0]   rdByte;

  // LSB-first fills from the top, so a full word lands in natural position
  always_comb begin
    if (strobe.lsbOrder) shiftNext = {dataBit, shiftReg[CMD_BITS-1:1]};
    else                 shiftNext = {shiftReg[CMD_BITS-2:0], dataBit};
  end

  assign cmdHi   = shiftNext[CMD_BITS-1:CMD_BITS-3];
  assign regAddr = addr;
  assign wrEn    = strobe.writeByte;
  assign wrData  = strobe.lsbOrder ? shiftNext[CMD_BITS-1:CMD_BITS-BYTE_W]
                                   : shiftNext[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addr     <= '0;
      rdByte   <= '0;
      outBit   <= 1'b0;
    end else begin
      if (strobe.shiftBit) shiftReg <= shiftNext;
      if (strobe.latchAddr)
        addr <= shiftNext[ADDR_W-1:0];
      else if (strobe.stepAddr)
        addr <= strobe.lsbOrder ? addr + 1'b1 : addr - 1'b1;
      if (strobe.loadRead) rdByte <= rdData;
      if (strobe.driveBit)
        outBit <= rdByte[strobe.lsbOrder ? strobe.bitIdx : ~strobe.bitIdx];
    end
  end
endmodule

// File: rtl/spiRegFile.sv
`timescale 1ns/1ps
module spiRegFile
  import spiPortPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              cfgLsb
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic [BYTE_W-1:0] regs [NUM_REGS];
  logic inRange;

  assign inRange = addr < LIMIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wrEn && inRange) begin
      regs[addr[IDX_W-1:0]] <= wrData;
    end
  end

  assign rdData = inRange ? regs[addr[IDX_W-1:0]] : '0;
  assign cfgLsb = regs[0][0];
endmodule

// File: rtl/spiRegPort.sv
`timescale 1ns/1ps
module spiRegPort
  import spiPortPkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiCsN,
  input  logic spiDataIn,
  output logic spiDataOut,
  output logic spiDataOe
);
  logic              sclkRise, sclkFall, csActive, dataBit;
  logic              rdOn, cfgLsb, wrEn, outBit;
  logic [2:0]        cmdHi;
  logic [ADDR_W-1:0] regAddr;
  logic [BYTE_W-1:0] wrData, rdData;
  strobe_t           strobe;

  spiPinSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .sclkPin(spiClk), .csNPin(spiCsN), .dataPin(spiDataIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csActive(csActive), .dataBit(dataBit)
  );

  spiPortCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csActive(csActive),
    .cmdHi(cmdHi), .cfgLsb(cfgLsb),
    .strobe(strobe), .rdOn(rdOn)
  );

  spiPortData uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .dataBit(dataBit), .rdData(rdData),
    .cmdHi(cmdHi), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .outBit(outBit)
  );

  spiRegFile #(.NUM_REGS(NUM_REGS)) uRegs (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .addr(regAddr), .wrData(wrData),
    .rdData(rdData), .cfgLsb(cfgLsb)
  );

  assign spiDataOe  = rdOn & csActive;
  assign spiDataOut = outBit & spiDataOe;
endmodule

// File: rtl/spiRegPortChk.sv
`timescale 1ns/1ps
module spiRegPortChk (
  input logic clk,
  input logic rstN,
  input logic csActive,
  input logic sclkRise,
  input logic sclkFall,
  input logic rdOn,
  input logic writeByte,
  input logic latchAddr,
  input logic stepAddr,
  input logic driveBit
);
  // R1
  edgeExclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sclkRise, sclkFall}));

  // R6
  oeTurnOnFall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdOn) |-> $past(sclkFall));

  // R6
  driveOnFall_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveBit |-> sclkFall);

  // R9
  writeOnRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeByte |-> sclkRise);

  // R5
  noWriteReleased_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !writeByte);

  // R7
  addrSingleOp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({latchAddr, stepAddr, driveBit}));
endmodule

bind spiRegPort spiRegPortChk uChk (
  .clk(clk), .rstN(rstN),
  .csActive(csActive), .sclkRise(sclkRise), .sclkFall(sclkFall),
  .rdOn(rdOn), .writeByte(strobe.writeByte),
  .latchAddr(strobe.latchAddr), .stepAddr(strobe.stepAddr),
  .driveBit(strobe.driveBit)
);

// File: tb/spiRegPort_test.sv
`timescale 1ns/1ps
module spiRegPort_test;
  localparam int NUM_REGS = 8;
  localparam int HALF     = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiClk = 1'b0;
  logic spiCsN = 1'b1;
  logic spiDataIn = 1'b0;
  logic spiDataOut, spiDataOe;

  always #5 clk = ~clk;

  spiRegPort #(.NUM_REGS(NUM_REGS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiDataIn(spiDataIn), .spiDataOut(spiDataOut), .spiDataOe(spiDataOe)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit tbLsb = 0;
  logic [7:0] mdl [NUM_REGS];
  logic [7:0] wbuf [8];
  logic [7:0] expVal [$];
  string      expTag [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mdlRead(input logic [12:0] a);
    return (a < 13'(NUM_REGS)) ? mdl[a[2:0]] : 8'h00;
  endfunction

  function automatic logic [12:0] stepAddr(input logic [12:0] a);
    return tbLsb ? a + 13'd1 : a - 13'd1;
  endfunction

  // Monitor: assembles driven read bytes and compares with the scoreboard
  initial begin
    int monBits = 0;
    logic [7:0] monByte = '0;
    forever begin
      @(posedge spiClk or posedge spiCsN);
      if (spiCsN) monBits = 0;
      else if (spiDataOe) begin
        monByte = tbLsb ? {spiDataOut, monByte[7:1]} : {monByte[6:0], spiDataOut};
        monBits++;
        if (monBits == 8) begin
          monBits = 0;
          if (expVal.size() == 0)
            check(1'b0, "R6", "unexpected read byte", 32'(monByte), 32'h0);
          else begin
            logic [7:0] v;
            string t;
            v = expVal.pop_front();
            t = expTag.pop_front();
            check(monByte == v, t, "read byte", 32'(monByte), 32'(v));
          end
        end
      end
    end
  end

  task automatic clockBit(input logic b, output logic oe);
    spiDataIn = b;
    #(HALF);
    oe = spiDataOe;
    spiClk = 1'b1;
    #(HALF);
    spiClk = 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] w, input int n, output int oeCnt);
    logic oe;
    oeCnt = 0;
    for (int i = 0; i < n; i++) begin
      clockBit(w[tbLsb ? i : n - 1 - i], oe);
      if (oe) oeCnt++;
    end
  endtask

  task automatic csLow();
    spiCsN = 1'b0;
    #(HALF);
  endtask

  task automatic csHigh();
    #(HALF);
    spiCsN = 1'b1;
    #(4 * HALF);
  endtask

  task automatic sendCmd(input logic rd, input logic [1:0] len, input logic [12:0] a,
                         output int oeCnt);
    sendBits({rd, len, a}, 16, oeCnt);
  endtask

  task automatic writeFrame(input logic [1:0] len, input logic [12:0] a0, input int n,
                            input bit stall, input bit startCs, input bit endCs);
    int oeCnt;
    logic [12:0] a = a0;
    if (startCs) csLow();
    sendCmd(1'b0, len, a0, oeCnt);
    for (int k = 0; k < n; k++) begin
      if (stall && k > 0) begin
        csHigh();
        csLow();
      end
      sendBits({8'h00, wbuf[k]}, 8, oeCnt);
      if (a < 13'(NUM_REGS)) mdl[a[2:0]] = wbuf[k];
      a = stepAddr(a);
    end
    if (endCs) csHigh();
  endtask

  task automatic readFrame(input logic [1:0] len, input logic [12:0] a0, input int n,
                           input bit stall, input bit startCs, input bit endCs,
                           input string tag);
    int oeCnt;
    int dataOe = 0;
    logic [12:0] a = a0;
    for (int k = 0; k < n; k++) begin
      expVal.push_back(mdlRead(a));
      expTag.push_back(tag);
      a = stepAddr(a);
    end
    if (startCs) csLow();
    sendCmd(1'b1, len, a0, oeCnt);
    check(oeCnt == 0, "R6", "enable during command bits", 32'(oeCnt), 32'h0);
    for (int k = 0; k < n; k++) begin
      if (stall && k > 0) begin
        #(HALF);
        spiCsN = 1'b1;
        #(3 * HALF);
        check(spiDataOe == 1'b0, "R6", "enable while select high", 32'(spiDataOe), 32'h0);
        csLow();
      end
      sendBits(16'h0000, 8, oeCnt);
      dataOe += oeCnt;
    end
    check(dataOe == 8 * n, "R6", "enable during data bits", 32'(dataOe), 32'(8 * n));
    if (endCs) begin
      csHigh();
      check(spiDataOe == 1'b0, "R6", "enable after frame", 32'(spiDataOe), 32'h0);
    end
  endtask

  initial begin
    int oeCnt;
    for (int i = 0; i < NUM_REGS; i++) mdl[i] = 8'h00;
    #3;
    #(100);
    rstN = 1'b1;
    #(4 * HALF);

    // R10: reset state
    check(spiDataOe == 1'b0, "R10", "enable after reset", 32'(spiDataOe), 32'h0);
    readFrame(2'b01, 13'd1, 2, 0, 1, 1, "R10");

    // R1 R2: single byte write then read
    wbuf[0] = 8'hA5;
    writeFrame(2'b00, 13'd3, 1, 0, 1, 1);
    readFrame(2'b00, 13'd3, 1, 0, 1, 1, "R1");

    // R2 R7: three bytes downward from 5, then two and three byte reads
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    writeFrame(2'b10, 13'd5, 3, 0, 1, 1);
    readFrame(2'b10, 13'd5, 3, 0, 1, 1, "R7");
    readFrame(2'b01, 13'd4, 2, 0, 1, 1, "R2");

    // R9: unimplemented address ignored, reads zero
    wbuf[0] = 8'h5A;
    writeFrame(2'b00, 13'd20, 1, 0, 1, 1);
    readFrame(2'b00, 13'd20, 1, 0, 1, 1, "R9");

    // R3: streaming write from 7 down to 3, streaming read across 7..2
    wbuf[0] = 8'hC7; wbuf[1] = 8'hC6; wbuf[2] = 8'hC5; wbuf[3] = 8'hC4; wbuf[4] = 8'hC3;
    writeFrame(2'b11, 13'd7, 5, 0, 1, 1);
    readFrame(2'b11, 13'd7, 6, 0, 1, 1, "R3");

    // R4: stalls between bytes on write and read
    wbuf[0] = 8'h96; wbuf[1] = 8'h69; wbuf[2] = 8'hF0;
    writeFrame(2'b10, 13'd6, 3, 1, 1, 1);
    readFrame(2'b10, 13'd6, 3, 1, 1, 1, "R4");

    // R5: abort inside a data byte leaves register 6 untouched
    csLow();
    sendCmd(1'b0, 2'b00, 13'd6, oeCnt);
    sendBits(16'h000F, 4, oeCnt);
    csHigh();
    readFrame(2'b00, 13'd6, 1, 0, 1, 1, "R5");
    // R5: abort inside the command, next frame decodes cleanly
    csLow();
    sendBits(16'h001F, 5, oeCnt);
    csHigh();
    wbuf[0] = 8'h3C;
    writeFrame(2'b00, 13'd2, 1, 0, 1, 1);
    readFrame(2'b00, 13'd2, 1, 0, 1, 1, "R5");

    // R2: back-to-back frames with select held low
    wbuf[0] = 8'h7E;
    writeFrame(2'b00, 13'd1, 1, 0, 1, 0);
    readFrame(2'b00, 13'd1, 1, 0, 0, 1, "R2");

    // R8: switch to LSB-first through register 0 bit 0
    wbuf[0] = 8'h01;
    writeFrame(2'b00, 13'd0, 1, 0, 1, 1);
    tbLsb = 1;
    wbuf[0] = 8'h81; wbuf[1] = 8'h42; wbuf[2] = 8'h2C;
    writeFrame(2'b10, 13'd1, 3, 0, 1, 1);
    readFrame(2'b10, 13'd1, 3, 0, 1, 1, "R8");
    // R7: LSB-first stream climbs past the last register
    readFrame(2'b11, 13'd6, 4, 0, 1, 1, "R7");

    #(4 * HALF);
    check(expVal.size() == 0, "R6", "read bytes outstanding", 32'(expVal.size()), 32'h0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule